// File: doc/BRIEF.md
# Eight-Neighbour Toroidal Mesh Shifter

This block moves 4-bit nibbles between the processing elements of a two-dimensional array, arranged as ROWS by COLS, where each element holds one transmit nibble. One central command applies to every element at the same time. The command names one of eight compass directions and a hop count. On each hop, every element passes its nibble to the neighbour in that direction. The mesh is a torus: a nibble that leaves one edge enters again on the opposite edge. On a diagonal hop, the row index and the column index wrap independently of each other.

A controller first fills all transmit registers in one cycle through the parallel load bus. It then issues a shift command. It watches `busy` for the duration of the shift and `done` for its completion. To move a word wider than 4 bits, the controller issues one shift command per nibble, in whatever nibble order it chooses. The arithmetic units of the elements and any global routing fabric sit outside this block.

Top module: `xmesh_shift_top`

## Requirements
- R1: A synchronous active-high reset, applied at any time including in the middle of a shift, clears every nibble to 0 and clears `busy` and `done` on the next clock edge.
- R2: While `busy` is low, `load_en` copies `load_data` into all elements at the next edge. Element (r,c) sits at bits [(r*COLS+c)*4 +: 4] of both buses. Row 0 is the northern edge and column 0 is the western edge. While `busy` is high, `load_en` has no effect.
- R3: `cmd_dir` selects the direction in which data moves on each hop as a (row, column) step: 0 north (-1,0), 1 northeast (-1,+1), 2 east (0,+1), 3 southeast (+1,+1), 4 south (+1,0), 5 southwest (+1,-1), 6 west (0,-1), 7 northwest (-1,-1).
- R4: Indices wrap modulo ROWS for rows and modulo COLS for columns. After k hops with step (dr,dc), element (r,c) holds the nibble that started at ((r-k*dr) mod ROWS, (c-k*dc) mod COLS).
- R5: A command accepted at edge E0 with distance k (1 to 15) performs hops at edges E1 to Ek. `busy` is high from E0 until Ek, which is exactly k cycles. `done` is high for the single cycle after Ek and is never high together with `busy`.
- R6: A command with distance 0 is ignored. A command presented while `busy` is high is ignored.
- R7: The direction and the distance are captured at acceptance. Changes on `cmd_dir` or `cmd_dist` during a shift have no effect on it.
- R8: While `busy` and `load_en` are both low, every nibble holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load strobe for all transmit nibbles |
| load_data | input | ROWS*COLS*4 | Nibbles to load, element (r,c) at slot r*COLS+c |
| cmd_valid | input | 1 | Shift command strobe |
| cmd_dir | input | 3 | Direction code of the shift |
| cmd_dist | input | 4 | Number of hops, 0 means no command |
| busy | output | 1 | High while hops are in progress |
| done | output | 1 | One-cycle pulse after the final hop |
| cell_data | output | ROWS*COLS*4 | Current transmit nibble of every element |

## Verification
A load is visible on `cell_data` one edge after the strobe. A command raises `busy` one edge after it is accepted. The final hop lands k edges after acceptance, and `done` goes high in that same cycle. The bench drives its inputs and samples its outputs on falling edges. It counts the falling edges at which `busy` is high and expects that count to equal k. It then compares the whole bus against a torus model and checks that `done` is high at that moment and low one cycle later. The stimulus covers every direction, distances that wrap the full mesh back to the identity, diagonal wraps at a corner, a command sent during a shift, a load sent during a shift, and a reset in the middle of a shift.

// File: rtl/xmesh_pkg.sv
package xmesh_pkg;

  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_NE = 3'd1,
    DIR_E  = 3'd2,
    DIR_SE = 3'd3,
    DIR_S  = 3'd4,
    DIR_SW = 3'd5,
    DIR_W  = 3'd6,
    DIR_NW = 3'd7
  } hop_dir_e;

  localparam int NUM_DIRS = 8;

  // Row step of one hop in direction d (row 0 is the north edge).
  function automatic int hop_drow(input int d);
    case (d)
      0, 1, 7: hop_drow = -1;
      3, 4, 5: hop_drow = 1;
      default: hop_drow = 0;
    endcase
  endfunction

  // Column step of one hop in direction d (column 0 is the west edge).
  function automatic int hop_dcol(input int d);
    case (d)
      1, 2, 3: hop_dcol = 1;
      5, 6, 7: hop_dcol = -1;
      default: hop_dcol = 0;
    endcase
  endfunction

endpackage

// File: rtl/xmesh_hop_ctrl.sv
module xmesh_hop_ctrl #(
  parameter int DIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_dir,
  input  logic [DIST_W-1:0] cmd_dist,
  output logic              busy,
  output logic              done,
  output logic [2:0]        dir_q
);

  logic [DIST_W-1:0] hops_left;
  logic              accept;

  assign accept = cmd_valid && !busy && (cmd_dist != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      hops_left <= '0;
      dir_q     <= 3'd0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        hops_left <= cmd_dist;
        dir_q     <= cmd_dir;
      end else if (busy) begin
        if (hops_left == DIST_W'(1)) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          hops_left <= '0;
        end else begin
          hops_left <= hops_left - DIST_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/xmesh_cell.sv
module xmesh_cell #(
  parameter int NIB_W  = 4,
  parameter int N_SRC  = 8,
  localparam int BUS_W = NIB_W * N_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [NIB_W-1:0] load_nib,
  input  logic             hop_en,
  input  logic [2:0]       sel,
  input  logic [BUS_W-1:0] nbr_bus,
  output logic [NIB_W-1:0] q
);

  logic [NIB_W-1:0] picked;

  assign picked = nbr_bus[sel*NIB_W +: NIB_W];

  // A hop takes priority, so a load during a shift is dropped.
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (hop_en)  q <= picked;
    else if (load_en) q <= load_nib;
  end

endmodule

// File: rtl/xmesh_shift_top.sv
module xmesh_shift_top
  import xmesh_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 6,
  parameter int NIB_W  = 4,
  parameter int DIST_W = 4,
  localparam int CELLS = ROWS * COLS,
  localparam int BUS_W = CELLS * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [BUS_W-1:0]  load_data,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_dir,
  input  logic [DIST_W-1:0] cmd_dist,
  output logic              busy,
  output logic              done,
  output logic [BUS_W-1:0]  cell_data
);

  localparam int NBR_W = NUM_DIRS * NIB_W;

  logic [2:0]       dir_q;
  logic [NIB_W-1:0] cell_q  [CELLS];
  logic [NBR_W-1:0] nbr_bus [CELLS];

  xmesh_hop_ctrl #(.DIST_W(DIST_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_dir   (cmd_dir),
    .cmd_dist  (cmd_dist),
    .busy      (busy),
    .done      (done),
    .dir_q     (dir_q)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;

      // Destination (r,c) receives from (r-dr, c-dc), wrapped per axis.
      for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        localparam int SRC_R = (r - hop_drow(d) + ROWS) % ROWS;
        localparam int SRC_C = (c - hop_dcol(d) + COLS) % COLS;
        assign nbr_bus[IDX][d*NIB_W +: NIB_W] = cell_q[SRC_R * COLS + SRC_C];
      end

      xmesh_cell #(.NIB_W(NIB_W), .N_SRC(NUM_DIRS)) cell_i (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_nib (load_data[IDX*NIB_W +: NIB_W]),
        .hop_en   (busy),
        .sel      (dir_q),
        .nbr_bus  (nbr_bus[IDX]),
        .q        (cell_q[IDX])
      );

      assign cell_data[IDX*NIB_W +: NIB_W] = cell_q[IDX];
    end
  end

endmodule

// File: rtl/xmesh_shift_chk.sv
module xmesh_shift_chk #(
  parameter int ROWS   = 4,
  parameter int COLS   = 6,
  parameter int NIB_W  = 4,
  parameter int DIST_W = 4,
  localparam int BUS_W = ROWS * COLS * NIB_W
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic [BUS_W-1:0]  load_data,
  input logic              cmd_valid,
  input logic [DIST_W-1:0] cmd_dist,
  input logic              busy,
  input logic              done,
  input logic [BUS_W-1:0]  cell_data,
  input logic [2:0]        dir_q
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !done && cell_data == '0));

  a_r2_load_lands: assert property (@(posedge clk) disable iff (rst)
    (load_en && !busy) |=> (cell_data == $past(load_data)));

  a_r4_east_wrap: assert property (@(posedge clk) disable iff (rst)
    (busy && dir_q == 3'd2) |=>
      (cell_data[0 +: NIB_W] == $past(cell_data[(COLS-1)*NIB_W +: NIB_W])));

  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r5_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  a_r6_accept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_dist != '0) |=> busy);

  a_r6_zero_dist: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_dist == '0) |=> !busy);

  a_r7_dir_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dir_q));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load_en) |=> $stable(cell_data));

endmodule

bind xmesh_shift_top xmesh_shift_chk #(
  .ROWS(ROWS), .COLS(COLS), .NIB_W(NIB_W), .DIST_W(DIST_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .load_data (load_data),
  .cmd_valid (cmd_valid),
  .cmd_dist  (cmd_dist),
  .busy      (busy),
  .done      (done),
  .cell_data (cell_data),
  .dir_q     (dir_q)
);

// File: tb/xmesh_shift_top_tb_top.sv
`timescale 1ns/1ps
module xmesh_shift_top_tb_top;

  localparam int R  = 4;
  localparam int C  = 6;
  localparam int NB = 4;
  localparam int W  = R * C * NB;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_en = 1'b0;
  logic [W-1:0] load_data = '0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_dir = 3'd0;
  logic [3:0]   cmd_dist = 4'd0;
  logic         busy, done;
  logic [W-1:0] cell_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  xmesh_shift_top #(.ROWS(R), .COLS(C), .NIB_W(NB), .DIST_W(4)) dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
    .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .cmd_dist(cmd_dist),
    .busy(busy), .done(done), .cell_data(cell_data)
  );

  // Vector: {dir[2:0], dist[3:0], seed[3:0]}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 4'd1,  4'd1}, {3'd1, 4'd1,  4'd2}, {3'd2, 4'd1,  4'd3},
    {3'd3, 4'd2,  4'd4}, {3'd4, 4'd3,  4'd5}, {3'd5, 4'd5,  4'd6},
    {3'd6, 4'd7,  4'd7}, {3'd7, 4'd9,  4'd8}, {3'd0, 4'd4,  4'd9},
    {3'd2, 4'd6,  4'd10},{3'd3, 4'd12, 4'd11},{3'd7, 4'd15, 4'd12},
    {3'd1, 4'd13, 4'd13},{3'd5, 4'd1,  4'd14}
  };

  function automatic logic [W-1:0] pattern(input int seed);
    logic [W-1:0] p;
    for (int i = 0; i < R*C; i++) p[i*NB +: NB] = 4'((i*5 + seed*3 + i/4) & 15);
    return p;
  endfunction

  // Torus model: after k hops, (r,c) holds the start value at (r-k*dr, c-k*dc).
  function automatic logic [W-1:0] model(input logic [W-1:0] s, input int dir, input int k);
    logic [W-1:0] o;
    int dr, dc, sr, sc;
    case (dir)
      0: begin dr = -1; dc = 0;  end
      1: begin dr = -1; dc = 1;  end
      2: begin dr = 0;  dc = 1;  end
      3: begin dr = 1;  dc = 1;  end
      4: begin dr = 1;  dc = 0;  end
      5: begin dr = 1;  dc = -1; end
      6: begin dr = 0;  dc = -1; end
      default: begin dr = -1; dc = -1; end
    endcase
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        sr = (r - k*dr) % R; if (sr < 0) sr += R;
        sc = (c - k*dc) % C; if (sc < 0) sc += C;
        o[(r*C+c)*NB +: NB] = s[(sr*C+sc)*NB +: NB];
      end
    return o;
  endfunction

  task automatic chk_bus(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] p);
    @(negedge clk); load_en = 1'b1; load_data = p;
    @(negedge clk); load_en = 1'b0;
    chk_bus("R2 load", cell_data, p);
  endtask

  // Issues a command and counts busy cycles on falling edges.
  task automatic shift_and_check(input int dir, input int k, input logic [W-1:0] p,
                                 input bool_inject);
    int n;
    cmd_valid = 1'b1; cmd_dir = 3'(dir); cmd_dist = 4'(k);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (bool_inject) begin
      cmd_valid = 1'b1; cmd_dir = 3'(dir ^ 4); cmd_dist = 4'd9;
      load_en = 1'b1; load_data = ~p;
      @(negedge clk);
      cmd_valid = 1'b0; load_en = 1'b0; cmd_dir = 3'd1; cmd_dist = 4'd2;
      n = 1;
    end else n = 0;
    while (busy && n < 40) begin n++; @(negedge clk); end
    chk_int("R5 busy cycles", n, k);
    chk_int("R5 done pulse", int'(done), 1);
    chk_bus("R3/R4 shifted data", cell_data, model(p, dir, k));
    @(negedge clk);
    chk_int("R5 done one cycle", int'(done), 0);
  endtask

  initial begin
    logic [W-1:0] p, hold;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk_bus("R1 data after reset", cell_data, '0);
    chk_int("R1 busy after reset", int'(busy), 0);
    chk_int("R1 done after reset", int'(done), 0);

    // Table walk: R3, R4, R5
    for (int v = 0; v < NV; v++) begin
      p = pattern(int'(VEC[v][3:0]));
      load(p);
      shift_and_check(int'(VEC[v][10:8]), int'(VEC[v][7:4]), p, 1'b0);
    end

    // R6: distance zero is ignored
    p = pattern(3);
    load(p);
    cmd_valid = 1'b1; cmd_dir = 3'd2; cmd_dist = 4'd0;
    @(negedge clk); cmd_valid = 1'b0;
    chk_int("R6 zero distance no busy", int'(busy), 0);
    @(negedge clk);
    chk_bus("R6 zero distance data", cell_data, p);

    // R6/R7 and R2: command and load during a shift are dropped
    p = pattern(11);
    load(p);
    shift_and_check(2, 3, p, 1'b1);

    // R8: idle hold
    hold = cell_data;
    repeat (6) @(negedge clk);
    chk_bus("R8 idle hold", cell_data, hold);

    // R1: reset mid-shift
    p = pattern(6);
    load(p);
    cmd_valid = 1'b1; cmd_dir = 3'd4; cmd_dist = 4'd10;
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_int("R1 busy cleared mid-shift", int'(busy), 0);
    chk_bus("R1 data cleared mid-shift", cell_data, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule